// File: doc/BRIEF.md
# Table-Less Up/Down Route Computation Unit

This unit chooses the output port for each wormhole packet that reaches one router of an irregular on-chip network. It needs no per-destination routing table. A handful of configuration bits stand in for it: one connectivity bit for each of the up and down ports, and four turn-permission bits. Three membership masks indexed by destination ID complete the configuration: same-level neighbour, ancestor and descendant. Links are oriented along a spanning tree. "Up" points toward the parent, or toward the lower ID between two routers on the same tree level. "Down" is the reverse. The one forbidden turn is a down hop followed by an up hop.

The decision is made in two combinational stages. A comparator stage looks at the destination's ID and level against the router's own. It yields an upward-direction flag, a downward-direction flag and the relevant mask hits. A small cone per output port then turns those into a one-hot request, with local before up before down. The unit computes the route only on a header flit and registers it. Body and tail flits reuse the held route until the tail closes the packet. Configuration is written through a simple write port that is honoured only while no packet is open. A read port returns each register.

Top module: `updown_route_unit`

## Requirements
- R1: After reset, fwd_valid and route_err are 0 and all four configuration registers read as 0.
- R2: Control register (address 0) layout: bit0 up connectivity, bit1 down connectivity, bit2 up-then-up permit, bit3 up-then-down permit, bit4 down-then-down permit, bit5 down-then-up permit, bits [9:6] own ID, bits [12:10] own level. Bit5 always reads 0, and writing 1 to it has no effect on the other fields. Addresses 1, 2 and 3 hold the same-level neighbour, ancestor and descendant masks, with bit i standing for destination ID i.
- R3: A header whose destination ID equals the own ID selects the local port (fwd_port 3'b001), whatever its level and the rest of the configuration.
- R4: A header for another ID at the same level selects the up port (3'b010) exactly when the neighbour-mask bit for that ID and up connectivity are both 1.
- R5: A header whose level is below the own level selects the up port exactly when the ancestor-mask bit, the up-then-up permit and up connectivity are all 1.
- R6: A header whose level is above the own level selects the down port (3'b100) exactly when the descendant-mask bit, the down-then-down permit and down connectivity are all 1.
- R7: When a header qualifies for no port, route_err is 1 and fwd_valid is 0 in the next cycle. Later flits of that packet are not forwarded and raise no error.
- R8: One cycle after an accepted header that qualifies for a port, fwd_valid is 1 and fwd_port is one-hot.
- R9: Body and tail flits of an open packet are forwarded one cycle later on the header's port. Their destination fields are ignored.
- R10: A tail flit closes the packet, and the next header is routed afresh. A non-header flit arriving while no packet is open produces no output.
- R11: Configuration writes made while a packet is open leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write address (0 control, 1 neighbour, 2 ancestor, 3 descendant) |
| cfg_wdata | input | DW (16) | Write data |
| cfg_raddr | input | 2 | Read address |
| cfg_rdata | output | DW (16) | Read data, combinational |
| flit_valid | input | 1 | Flit present this cycle |
| flit_head | input | 1 | Flit is a header |
| flit_tail | input | 1 | Flit is the last of its packet |
| flit_dest_id | input | ID_W (4) | Destination router ID from the header |
| flit_dest_lvl | input | LVL_W (3) | Destination tree level from the header |
| fwd_valid | output | 1 | Flit forwarded, one cycle after acceptance |
| fwd_port | output | 3 | One-hot port: bit0 local, bit1 up, bit2 down |
| route_err | output | 1 | Header matched no port |

## Verification
The hardest situation to reach from the ports is a mismatch between a held route and the header fields of the flits that follow it. Configuration writes attempted during an open packet belong to the same problem. Both need a packet that stays open across several cycles, with contrary stimulus arriving inside it. The bench opens a packet without a tail and sends body flits whose destination fields would select a different port. It also attempts a register write, which it reads back, before the tail closes the packet. The routing cones are swept exhaustively: 32 configurations cover every combination of the connectivity and permit bits across several own IDs, levels and mask patterns, and each configuration is tried against every destination ID and level.

// File: rtl/updown_route_pkg.sv
package updown_route_pkg;
  localparam int PORTS = 3;
  localparam int P_LOCAL = 0;
  localparam int P_UP    = 1;
  localparam int P_DOWN  = 2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_NBR  = 2'd1;
  localparam logic [1:0] A_ANC  = 2'd2;
  localparam logic [1:0] A_DESC = 2'd3;

  localparam int B_CUP = 0;
  localparam int B_CDN = 1;
  localparam int B_RUU = 2;
  localparam int B_RUD = 3;
  localparam int B_RDD = 4;
  localparam int B_RDU = 5;
  localparam int B_ID  = 6;
endpackage

// File: rtl/updown_cfg_regs.sv
module updown_cfg_regs
  import updown_route_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LVL_W = 3,
  parameter int N     = 16,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [1:0]       raddr,
  output logic [DW-1:0]    rdata,
  output logic             c_up,
  output logic             c_dn,
  output logic             r_uu,
  output logic             r_dd,
  output logic [ID_W-1:0]  my_id,
  output logic [LVL_W-1:0] my_lvl,
  output logic [N-1:0]     nbr_mask,
  output logic [N-1:0]     anc_mask,
  output logic [N-1:0]     desc_mask
);
  localparam int CTRL_W = B_ID + ID_W + LVL_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [N-1:0]      mask_q [3];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && waddr == A_CTRL) begin
      ctrl_d        = wdata[CTRL_W-1:0];
      ctrl_d[B_RDU] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar g = 0; g < 3; g++) begin : g_mask
    logic [N-1:0] m_q, m_d;
    always_comb m_d = (wr_en && waddr == 2'(g + 1)) ? wdata[N-1:0] : m_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '0;
      else        m_q <= m_d;
    end
    assign mask_q[g] = m_q;
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      A_NBR:   rdata[N-1:0] = mask_q[0];
      A_ANC:   rdata[N-1:0] = mask_q[1];
      default: rdata[N-1:0] = mask_q[2];
    endcase
  end

  assign c_up      = ctrl_q[B_CUP];
  assign c_dn      = ctrl_q[B_CDN];
  assign r_uu      = ctrl_q[B_RUU];
  assign r_dd      = ctrl_q[B_RDD];
  assign my_id     = ctrl_q[B_ID +: ID_W];
  assign my_lvl    = ctrl_q[B_ID + ID_W +: LVL_W];
  assign nbr_mask  = mask_q[0];
  assign anc_mask  = mask_q[1];
  assign desc_mask = mask_q[2];

  // R2: the forbidden-turn permit never becomes visible after any write
  p_du_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr == A_CTRL) |-> !rdata[B_RDU]);
endmodule

// File: rtl/updown_compare.sv
module updown_compare #(
  parameter int ID_W  = 4,
  parameter int LVL_W = 3,
  parameter int N     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  my_id,
  input  logic [LVL_W-1:0] my_lvl,
  input  logic [ID_W-1:0]  dest_id,
  input  logic [LVL_W-1:0] dest_lvl,
  input  logic [N-1:0]     nbr_mask,
  input  logic [N-1:0]     anc_mask,
  input  logic [N-1:0]     desc_mask,
  output logic             u1,
  output logic             d1,
  output logic             hit_direct,
  output logic             hit_anc,
  output logic             hit_desc
);
  logic same_id, lvl_eq, lvl_lt, lvl_gt;

  always_comb begin
    same_id    = (dest_id == my_id);
    lvl_eq     = (dest_lvl == my_lvl);
    lvl_lt     = (dest_lvl < my_lvl);
    lvl_gt     = (dest_lvl > my_lvl);
    u1         = !same_id && (lvl_eq || lvl_lt);
    d1         = !same_id && lvl_gt;
    hit_direct = lvl_eq && nbr_mask[dest_id];
    hit_anc    = lvl_lt && anc_mask[dest_id];
    hit_desc   = lvl_gt && desc_mask[dest_id];
  end

  // R3: a destination cannot lie both upward and downward
  p_dir_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(u1 && d1));
endmodule

// File: rtl/updown_port_logic.sv
module updown_port_logic
  import updown_route_pkg::*;
(
  input  logic             u1,
  input  logic             d1,
  input  logic             hit_direct,
  input  logic             hit_anc,
  input  logic             hit_desc,
  input  logic             c_up,
  input  logic             c_dn,
  input  logic             r_uu,
  input  logic             r_dd,
  output logic [PORTS-1:0] port_sel,
  output logic             no_route
);
  logic [PORTS-1:0] req;

  always_comb begin
    req[P_LOCAL] = !u1 && !d1;
    req[P_UP]    = c_up && u1 && (hit_direct || (hit_anc && r_uu));
    req[P_DOWN]  = c_dn && d1 && hit_desc && r_dd;
    port_sel = '0;
    if (req[P_LOCAL])     port_sel[P_LOCAL] = 1'b1;
    else if (req[P_UP])   port_sel[P_UP]    = 1'b1;
    else if (req[P_DOWN]) port_sel[P_DOWN]  = 1'b1;
    no_route = (req == '0);
  end
endmodule

// File: rtl/updown_route_unit.sv
module updown_route_unit
  import updown_route_pkg::*;
#(
  parameter  int ID_W   = 4,
  parameter  int LVL_W  = 3,
  localparam int N      = 1 << ID_W,
  localparam int CTRL_W = B_ID + ID_W + LVL_W,
  localparam int DW     = (N > CTRL_W) ? N : CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [1:0]        cfg_raddr,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              flit_valid,
  input  logic              flit_head,
  input  logic              flit_tail,
  input  logic [ID_W-1:0]   flit_dest_id,
  input  logic [LVL_W-1:0]  flit_dest_lvl,
  output logic              fwd_valid,
  output logic [PORTS-1:0]  fwd_port,
  output logic              route_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             c_up, c_dn, r_uu, r_dd;
  logic [ID_W-1:0]  my_id;
  logic [LVL_W-1:0] my_lvl;
  logic [N-1:0]     nbr_mask, anc_mask, desc_mask;
  logic             busy_q, busy_d;
  logic             cfg_wr_ok;

  assign cfg_wr_ok = cfg_we && !busy_q;

  updown_cfg_regs #(.ID_W(ID_W), .LVL_W(LVL_W), .N(N), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cfg_wr_ok), .waddr(cfg_addr),
    .wdata(cfg_wdata), .raddr(cfg_raddr), .rdata(cfg_rdata),
    .c_up(c_up), .c_dn(c_dn), .r_uu(r_uu), .r_dd(r_dd),
    .my_id(my_id), .my_lvl(my_lvl),
    .nbr_mask(nbr_mask), .anc_mask(anc_mask), .desc_mask(desc_mask)
  );

  logic u1, d1, hit_direct, hit_anc, hit_desc;

  updown_compare #(.ID_W(ID_W), .LVL_W(LVL_W), .N(N)) u_cmp (
    .clk(clk), .rst_n(rst_int_n),
    .my_id(my_id), .my_lvl(my_lvl),
    .dest_id(flit_dest_id), .dest_lvl(flit_dest_lvl),
    .nbr_mask(nbr_mask), .anc_mask(anc_mask), .desc_mask(desc_mask),
    .u1(u1), .d1(d1), .hit_direct(hit_direct), .hit_anc(hit_anc),
    .hit_desc(hit_desc)
  );

  logic [PORTS-1:0] port_sel;
  logic             no_route;

  updown_port_logic u_ports (
    .u1(u1), .d1(d1), .hit_direct(hit_direct), .hit_anc(hit_anc),
    .hit_desc(hit_desc), .c_up(c_up), .c_dn(c_dn), .r_uu(r_uu), .r_dd(r_dd),
    .port_sel(port_sel), .no_route(no_route)
  );

  // Wormhole hold: route latched on the header, reused until the tail
  logic [PORTS-1:0] held_q, held_d, port_d;
  logic             valid_d, err_d;

  always_comb begin
    busy_d  = busy_q;
    held_d  = held_q;
    valid_d = 1'b0;
    port_d  = '0;
    err_d   = 1'b0;
    if (flit_valid && flit_head) begin
      held_d  = port_sel;
      valid_d = !no_route;
      port_d  = port_sel;
      err_d   = no_route;
      busy_d  = !flit_tail;
    end else if (flit_valid && busy_q) begin
      valid_d = |held_q;
      port_d  = held_q;
      busy_d  = !flit_tail;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q    <= 1'b0;
      held_q    <= '0;
      fwd_valid <= 1'b0;
      fwd_port  <= '0;
      route_err <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      held_q    <= held_d;
      fwd_valid <= valid_d;
      fwd_port  <= port_d;
      route_err <= err_d;
    end
  end

  // R8: a forwarded flit names exactly one port
  p_onehot_fwd_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    fwd_valid |-> ($countones(fwd_port) == 1));

  // R7: an unroutable header is never forwarded
  p_err_nofwd_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    route_err |-> !fwd_valid);

  // R9: a body flit of an open packet leaves on the held port
  p_body_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && flit_valid && !flit_head && (held_q != '0))
      |=> (fwd_valid && fwd_port == $past(held_q)));

  // R11: writes while a packet is open change no configuration
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_q && cfg_we) |=> ($stable(my_id) && $stable(my_lvl) && $stable(c_up)
      && $stable(c_dn) && $stable(nbr_mask) && $stable(anc_mask)
      && $stable(desc_mask)));
endmodule

// File: tb/updown_route_unit_tb.sv
module updown_route_unit_tb;
  localparam int ID_W = 4;
  localparam int LVL_W = 3;
  localparam int N = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [1:0] cfg_raddr = '0;
  logic [DW-1:0] cfg_rdata;
  logic flit_valid = 1'b0, flit_head = 1'b0, flit_tail = 1'b0;
  logic [ID_W-1:0] flit_dest_id = '0;
  logic [LVL_W-1:0] flit_dest_lvl = '0;
  logic fwd_valid, route_err;
  logic [2:0] fwd_port;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic obs_v, obs_e;
  logic [2:0] obs_p;

  always #10 clk = ~clk;

  updown_route_unit #(.ID_W(ID_W), .LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .flit_valid(flit_valid), .flit_head(flit_head), .flit_tail(flit_tail),
    .flit_dest_id(flit_dest_id), .flit_dest_lvl(flit_dest_lvl),
    .fwd_valid(fwd_valid), .fwd_port(fwd_port), .route_err(route_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cfg_raddr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send(input logic h, input logic t, input logic [ID_W-1:0] id,
                      input logic [LVL_W-1:0] lv);
    @(negedge clk);
    flit_valid = 1'b1; flit_head = h; flit_tail = t;
    flit_dest_id = id; flit_dest_lvl = lv;
    @(posedge clk);
    #5;
    obs_v = fwd_valid; obs_p = fwd_port; obs_e = route_err;
    flit_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] mk_ctrl(input logic cu, cd, ruu, rud, rdd, rdu,
      input logic [ID_W-1:0] id, input logic [LVL_W-1:0] lv);
    logic [DW-1:0] v = '0;
    v[0] = cu; v[1] = cd; v[2] = ruu; v[3] = rud; v[4] = rdd; v[5] = rdu;
    v[9:6] = id; v[12:10] = lv;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] rd;
    repeat (9) @(negedge clk);

    // R1: reset state
    chk(fwd_valid == 0 && route_err == 0, "R1 outputs idle", {fwd_valid, route_err}, 0);
    for (int a = 0; a < 4; a++) begin
      cfg_read(2'(a), rd);
      chk(rd == 0, "R1 cfg reset", rd, 0);
    end

    // R2: layout and forbidden-turn bit
    cfg_write(2'd0, mk_ctrl(1, 0, 1, 1, 0, 1, 4'hB, 3'd5));
    cfg_read(2'd0, rd);
    chk(rd == mk_ctrl(1, 0, 1, 1, 0, 0, 4'hB, 3'd5), "R2 du ignored", rd,
        mk_ctrl(1, 0, 1, 1, 0, 0, 4'hB, 3'd5));
    cfg_write(2'd2, 16'hBEEF);
    cfg_read(2'd2, rd);
    chk(rd == 16'hBEEF, "R2 ancestor mask", rd, 16'hBEEF);

    // R3..R6, R7, R8: exhaustive sweep
    for (int k = 0; k < 32; k++) begin
      logic [ID_W-1:0] mid;
      logic [LVL_W-1:0] mlv;
      logic [N-1:0] nb, an, de;
      mid = 4'((k * 7 + 3) % 16);
      mlv = 3'((k * 3 + 1) % 8);
      nb = 16'h5A5A ^ 16'(k * 16'h1357);
      an = 16'h33CC ^ 16'(k * 16'h0F0F);
      de = 16'hC396 ^ 16'(k * 16'h2491);
      cfg_write(2'd0, mk_ctrl(k[0], k[1], k[2], k[4], k[3], 1'b0, mid, mlv));
      cfg_write(2'd1, nb);
      cfg_write(2'd2, an);
      cfg_write(2'd3, de);
      for (int d = 0; d < N; d++) begin
        for (int l = 0; l < 8; l++) begin
          logic [2:0] exp;
          string tag;
          if (d == mid) begin
            exp = 3'b001; tag = "R3 local";
          end else if (l == mlv) begin
            exp = (k[0] && nb[d]) ? 3'b010 : 3'b000; tag = "R4 same level";
          end else if (l < mlv) begin
            exp = (k[0] && k[2] && an[d]) ? 3'b010 : 3'b000; tag = "R5 ancestor";
          end else begin
            exp = (k[1] && k[3] && de[d]) ? 3'b100 : 3'b000; tag = "R6 descendant";
          end
          send(1'b1, 1'b1, 4'(d), 3'(l));
          if (exp == 3'b000)
            chk(!obs_v && obs_e, {tag, " R7 no port"}, {obs_v, obs_e}, 2'b01);
          else
            chk(obs_v && !obs_e && obs_p == exp, {tag, " R8 port"},
                {obs_v, obs_e, obs_p}, {2'b10, exp});
        end
      end
    end

    // R9, R10, R11: held route
    cfg_write(2'd0, mk_ctrl(1, 1, 1, 1, 1, 0, 4'd5, 3'd2));
    cfg_write(2'd1, 16'h0040);
    cfg_write(2'd2, 16'h0002);
    cfg_write(2'd3, 16'h0200);
    send(1'b1, 1'b0, 4'd9, 3'd4);
    chk(obs_v && obs_p == 3'b100, "R9 header down", obs_p, 3'b100);
    send(1'b0, 1'b0, 4'd1, 3'd0);
    chk(obs_v && obs_p == 3'b100, "R9 body keeps port", obs_p, 3'b100);
    cfg_write(2'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 4'd1, 3'd1));
    cfg_write(2'd3, 16'h0000);
    cfg_read(2'd0, rd);
    chk(rd == mk_ctrl(1, 1, 1, 1, 1, 0, 4'd5, 3'd2), "R11 ctrl frozen", rd,
        mk_ctrl(1, 1, 1, 1, 1, 0, 4'd5, 3'd2));
    cfg_read(2'd3, rd);
    chk(rd == 16'h0200, "R11 mask frozen", rd, 16'h0200);
    send(1'b0, 1'b1, 4'd5, 3'd2);
    chk(obs_v && obs_p == 3'b100, "R9 tail keeps port", obs_p, 3'b100);
    send(1'b0, 1'b0, 4'd9, 3'd4);
    chk(!obs_v && !obs_e, "R10 stray body dropped", {obs_v, obs_e}, 0);
    send(1'b1, 1'b1, 4'd1, 3'd0);
    chk(obs_v && obs_p == 3'b010, "R10 new header rerouted", obs_p, 3'b010);

    // R7: dropped packet
    send(1'b1, 1'b0, 4'd12, 3'd4);
    chk(!obs_v && obs_e, "R7 error header", {obs_v, obs_e}, 2'b01);
    send(1'b0, 1'b0, 4'd5, 3'd2);
    chk(!obs_v && !obs_e, "R7 body not forwarded", {obs_v, obs_e}, 0);
    send(1'b0, 1'b1, 4'd5, 3'd2);
    chk(!obs_v && !obs_e, "R7 tail not forwarded", {obs_v, obs_e}, 0);
    send(1'b1, 1'b1, 4'd5, 3'd6);
    chk(obs_v && obs_p == 3'b001, "R10 R3 after drop local", obs_p, 3'b001);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule